// File: doc/BRIEF.md
# PHY Register Word Bridge

This block lets several requesters read and write 16-bit PHY control registers that sit in a memory reachable only as aligned 64-bit words. A requester names a register by section (firmware block or per-thread memory block), a register offset, an optional lane number, and the number of the unit it serves. The bridge maps the unit to a thread, finds the thread's copy of the section, and adds the lane-replicated offset. It then doubles the register index into a byte address and issues aligned word accesses to the memory.

A read fetches the containing word once and returns the selected 16-bit field. A write fetches the word, replaces only the selected field and stores the word back. The whole access runs under one grant, so no other requester can touch the memory between the fetch and the store. Grants pass between requesters in round-robin order. A request that names an unmapped unit, or a per-lane register outside the per-lane range, finishes at once with an error and never reaches the memory.

Top module: `phyreg_bridge`

## Requirements
- R1: Units 0 to 7 map to threads 0,1,1,0,1,0,1,0 in that order. Any unit of 8 or above is invalid.
- R2: Section 0 (firmware) has base 0x111B0 and stride 0x10 per thread. Section 1 (memory) has base 0x12800 and stride 0x400 per thread. The thread's base is the section base plus the stride times the thread.
- R3: The register index is the offset, plus the lane times 16 when the lane enable is set. The byte address is the thread base plus twice the index. `mem_addr` is the byte address with bits [2:0] cleared.
- R4: Bits [2:1] of the byte address select a 16-bit slot, numbered from the most significant end of the word. Slot s occupies word bits [63-16s : 48-16s].
- R5: A write performs exactly one word read and then one word write to the same address. Only the selected slot changes, and it takes the write data. `done_rdata` returns the slot's previous value.
- R6: A read performs exactly one word read and no write. `done_rdata` returns the selected slot.
- R7: An invalid unit, or a lane-enabled request with offset 0x10 or above, raises `done` with `done_err`=1 and no memory access. A request without the lane enable accepts an offset of 0x10 or above.
- R8: Only one requester's sequence runs at a time. No requester is accepted while a memory access is outstanding, and at most one `req_ready` bit and one `done` bit are high at once. Concurrent writes to different slots of the same word therefore both survive.
- R9: When several requesters are valid, the grant goes to the first valid one after the most recently served one. After reset, requester 0 is first.
- R10: Once `mem_req` rises, it stays high with stable `mem_addr` and `mem_we` until `mem_ack`.
- R11: After reset, `mem_req`, `done` and `req_ready` are 0 while no request is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Request valid per requester |
| req_ready | output | NREQ | Request accepted this cycle |
| req_sect | input | NREQ | Section select, 0 firmware, 1 memory |
| req_lane_en | input | NREQ | Per-lane register access |
| req_lane | input | NREQ x 5 | Lane number |
| req_off | input | NREQ x 9 | Register offset |
| req_unit | input | NREQ x 4 | Unit number |
| req_we | input | NREQ | 1 write, 0 read |
| req_wdata | input | NREQ x 16 | Write data |
| done | output | NREQ | One-cycle completion pulse per requester |
| done_rdata | output | 16 | Read field, or the previous field on a write |
| done_err | output | 1 | Request rejected, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 20 | Aligned byte address of the word |
| mem_wdata | output | 64 | Word to store |
| mem_rdata | input | 64 | Word read, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
Accesses go to both sections from units on thread 0 and on thread 1, with and without the lane enable. Together they land in all four slots of a word, so a swapped table entry, a wrong stride, a missing lane shift or a reversed slot order each yields a distinct wrong address or field. Writes compare the whole stored word against a prediction, which separates a true merge from a clobbered neighbour. Two requesters write different slots of one word at the same time, to expose an interleaved sequence. Preceding lone requests steer the round-robin pointer so that either requester should win. Rejected requests are counted against memory traffic, and a high non-lane offset is accepted as the control case.

// File: rtl/phyreg_pkg.sv
package phyreg_pkg;

    localparam int ADDR_W       = 20;
    localparam int OFF_W        = 9;
    localparam int LANE_W       = 5;
    localparam int UNIT_W       = 4;
    localparam int DATA_W       = 16;
    localparam int WORD_W       = 64;
    localparam int NUM_UNITS    = 8;
    localparam int UIDX_W       = $clog2(NUM_UNITS);
    localparam int SLOTS        = WORD_W / DATA_W;
    localparam int SLOT_W       = $clog2(SLOTS);
    localparam int BYTE_SEL_W   = $clog2(WORD_W / 8);
    localparam int LANE_SHIFT   = 4;
    localparam int LANE_OFF_MAX = 16;

    // bit u gives the thread that serves unit u
    localparam logic [NUM_UNITS-1:0] THREAD_MAP = 8'b0101_0110;

    localparam logic [ADDR_W-1:0] FW_BASE   = 20'h111B0;
    localparam logic [ADDR_W-1:0] FW_STRIDE = 20'h00010;
    localparam logic [ADDR_W-1:0] MM_BASE   = 20'h12800;
    localparam logic [ADDR_W-1:0] MM_STRIDE = 20'h00400;

    typedef enum logic {SECT_FW = 1'b0, SECT_MM = 1'b1} sect_e;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} st_e;

    typedef struct packed {
        sect_e              sect;
        logic               lane_en;
        logic [LANE_W-1:0]  lane;
        logic [OFF_W-1:0]   off;
        logic [UNIT_W-1:0]  unit;
        logic               we;
        logic [DATA_W-1:0]  wdata;
    } req_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  waddr;
        logic [SLOT_W-1:0]  slot;
        logic               bad;
    } loc_t;

    // slot 0 is the most significant field of the word
    function automatic int slot_lsb(logic [SLOT_W-1:0] s);
        return (SLOTS - 1 - int'(s)) * DATA_W;
    endfunction

    function automatic logic [DATA_W-1:0] slot_get(logic [WORD_W-1:0] w,
                                                   logic [SLOT_W-1:0] s);
        logic [WORD_W-1:0] t;
        t = w >> slot_lsb(s);
        return t[DATA_W-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] slot_put(logic [WORD_W-1:0] w,
                                                   logic [SLOT_W-1:0] s,
                                                   logic [DATA_W-1:0] v);
        logic [WORD_W-1:0] m;
        logic [WORD_W-1:0] d;
        m = {{(WORD_W-DATA_W){1'b0}}, {DATA_W{1'b1}}} << slot_lsb(s);
        d = {{(WORD_W-DATA_W){1'b0}}, v} << slot_lsb(s);
        return (w & ~m) | d;
    endfunction

endpackage

// File: rtl/phyreg_locate.sv
module phyreg_locate
    import phyreg_pkg::*;
(
    input  req_t rq,
    output loc_t loc
);
    logic              unit_ok;
    logic              tid;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] index;
    logic [ADDR_W-1:0] byte_a;

    always_comb begin
        unit_ok = (rq.unit < UNIT_W'(NUM_UNITS));
        tid     = unit_ok ? THREAD_MAP[rq.unit[UIDX_W-1:0]] : 1'b0;
        if (rq.sect == SECT_MM)
            base = MM_BASE + MM_STRIDE * ADDR_W'(tid);
        else
            base = FW_BASE + FW_STRIDE * ADDR_W'(tid);
        index  = ADDR_W'(rq.off)
               + (rq.lane_en ? (ADDR_W'(rq.lane) << LANE_SHIFT) : '0);
        byte_a = base + (index << 1);
        loc.waddr = {byte_a[ADDR_W-1:BYTE_SEL_W], {BYTE_SEL_W{1'b0}}};
        loc.slot  = byte_a[BYTE_SEL_W-1 -: SLOT_W];
        loc.bad   = !unit_ok
                  || (rq.lane_en && (rq.off >= OFF_W'(LANE_OFF_MAX)))
                  || byte_a[0];
    end
endmodule

// File: rtl/phyreg_arb.sv
module phyreg_arb #(
    parameter int NREQ  = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  valid,
    input  logic             enable,
    output logic [NREQ-1:0]  grant,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);
    logic [IDX_W-1:0] last;

    always_comb begin
        any     = 1'b0;
        gnt_idx = last;
        for (int k = 1; k <= NREQ; k++) begin
            int c;
            c = int'(last) + k;
            if (c >= NREQ) c = c - NREQ;
            if (!any && valid[c]) begin
                any     = 1'b1;
                gnt_idx = IDX_W'(c);
            end
        end
        grant = (enable && any) ? (NREQ'(1) << gnt_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            last <= IDX_W'(NREQ - 1);
        else if (enable && any)
            last <= gnt_idx;
    end
endmodule

// File: rtl/phyreg_seq.sv
module phyreg_seq
    import phyreg_pkg::*;
#(
    parameter int IDX_W = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic               acc_we,
    input  logic [DATA_W-1:0]  acc_wdata,
    input  loc_t               acc_loc,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    output logic               idle,
    output logic               fin,
    output logic [IDX_W-1:0]   owner,
    output logic [DATA_W-1:0]  field,
    output logic               err,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata
);
    st_e               st;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] waddr_q;
    logic [SLOT_W-1:0] slot_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            owner   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            waddr_q <= '0;
            slot_q  <= '0;
            word_q  <= '0;
            field   <= '0;
            err     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (accept) begin
                    owner   <= acc_idx;
                    we_q    <= acc_we;
                    wdata_q <= acc_wdata;
                    waddr_q <= acc_loc.waddr;
                    slot_q  <= acc_loc.slot;
                    err     <= acc_loc.bad;
                    field   <= '0;
                    st      <= acc_loc.bad ? ST_FIN : ST_RD;
                end
                ST_RD: if (mem_ack) begin
                    field  <= slot_get(mem_rdata, slot_q);
                    word_q <= slot_put(mem_rdata, slot_q, wdata_q);
                    st     <= we_q ? ST_WR : ST_FIN;
                end
                ST_WR: if (mem_ack) st <= ST_FIN;
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign idle      = (st == ST_IDLE);
    assign fin       = (st == ST_FIN);
    assign mem_req   = (st == ST_RD) || (st == ST_WR);
    assign mem_we    = (st == ST_WR);
    assign mem_addr  = waddr_q;
    assign mem_wdata = word_q;
endmodule

// File: rtl/phyreg_bridge.sv
module phyreg_bridge
    import phyreg_pkg::*;
#(
    parameter int NREQ = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NREQ-1:0]               req_valid,
    output logic [NREQ-1:0]               req_ready,
    input  logic [NREQ-1:0]               req_sect,
    input  logic [NREQ-1:0]               req_lane_en,
    input  logic [NREQ-1:0][LANE_W-1:0]   req_lane,
    input  logic [NREQ-1:0][OFF_W-1:0]    req_off,
    input  logic [NREQ-1:0][UNIT_W-1:0]   req_unit,
    input  logic [NREQ-1:0]               req_we,
    input  logic [NREQ-1:0][DATA_W-1:0]   req_wdata,
    output logic [NREQ-1:0]               done,
    output logic [DATA_W-1:0]             done_rdata,
    output logic                          done_err,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [WORD_W-1:0]             mem_wdata,
    input  logic [WORD_W-1:0]             mem_rdata,
    input  logic                          mem_ack
);
    localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic             idle;
    logic             fin;
    logic             any;
    logic [IDX_W-1:0] gnt_idx;
    logic [IDX_W-1:0] owner;
    req_t             sel;
    loc_t             sel_loc;

    phyreg_arb #(.NREQ(NREQ), .IDX_W(IDX_W)) arb_i (
        .clk     (clk),
        .rst     (rst),
        .valid   (req_valid),
        .enable  (idle),
        .grant   (req_ready),
        .gnt_idx (gnt_idx),
        .any     (any)
    );

    always_comb begin
        sel.sect    = sect_e'(req_sect[gnt_idx]);
        sel.lane_en = req_lane_en[gnt_idx];
        sel.lane    = req_lane[gnt_idx];
        sel.off     = req_off[gnt_idx];
        sel.unit    = req_unit[gnt_idx];
        sel.we      = req_we[gnt_idx];
        sel.wdata   = req_wdata[gnt_idx];
    end

    phyreg_locate loc_i (
        .rq  (sel),
        .loc (sel_loc)
    );

    phyreg_seq #(.IDX_W(IDX_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .accept    (idle && any),
        .acc_idx   (gnt_idx),
        .acc_we    (sel.we),
        .acc_wdata (sel.wdata),
        .acc_loc   (sel_loc),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .idle      (idle),
        .fin       (fin),
        .owner     (owner),
        .field     (done_rdata),
        .err       (done_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign done = fin ? (NREQ'(1) << owner) : '0;
endmodule

// File: rtl/phyreg_checker.sv
module phyreg_checker #(
    parameter int NREQ = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [NREQ-1:0] req_ready,
    input logic [NREQ-1:0] done,
    input logic            done_err,
    input logic            mem_req,
    input logic            mem_we,
    input logic [19:0]     mem_addr,
    input logic            mem_ack
);
    p_one_ready_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    p_one_done_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (req_ready == '0));

    p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_err_no_mem_r7: assert property (@(posedge clk) disable iff (rst)
        ((done != '0) && done_err) |-> !$past(mem_req));

    p_store_follows_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |-> ($past(mem_req) && $stable(mem_addr)));
endmodule

bind phyreg_bridge phyreg_checker #(.NREQ(NREQ)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .done      (done),
    .done_err  (done_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/phyreg_bridge_tb_top.sv
`timescale 1ns/1ps
module phyreg_bridge_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [1:0]        req_valid = '0;
    logic [1:0]        req_ready;
    logic [1:0]        req_sect = '0;
    logic [1:0]        req_lane_en = '0;
    logic [1:0][4:0]   req_lane = '0;
    logic [1:0][8:0]   req_off = '0;
    logic [1:0][3:0]   req_unit = '0;
    logic [1:0]        req_we = '0;
    logic [1:0][15:0]  req_wdata = '0;
    logic [1:0]        done;
    logic [15:0]       done_rdata;
    logic              done_err;
    logic              mem_req, mem_we, mem_ack;
    logic [19:0]       mem_addr;
    logic [63:0]       mem_wdata, mem_rdata;

    phyreg_bridge #(.NREQ(2)) dut_i (.*);

    // memory model: one-cycle acknowledge
    logic [63:0] mem [0:1023];
    int          n_access = 0;
    int          n_write  = 0;
    logic [19:0] last_addr = '0;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        for (int k = 0; k < 1024; k++)
            mem[k] = {4{16'(k * 16'h0101 + 16'h5A0F)}};
    end

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            n_access++;
            last_addr = mem_addr;
            if (mem_we) begin
                n_write++;
                mem[mem_addr[12:3]] = mem_wdata;
            end
            mem_rdata <= mem[mem_addr[12:3]];
            mem_ack   <= 1'b1;
        end else begin
            mem_ack   <= 1'b0;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    int acc_cnt = 0;
    int order [2];
    bit finished = 0;

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_byte(bit sect, int unit, bit lane_en, int lane, int off);
        int thr;
        int base;
        thr  = (unit == 1 || unit == 2 || unit == 4 || unit == 6) ? 1 : 0;
        base = sect ? ('h12800 + 'h400 * thr) : ('h111B0 + 'h10 * thr);
        return base + 2 * (off + (lane_en ? lane * 16 : 0));
    endfunction

    function automatic logic [15:0] exp_field(logic [63:0] w, int byte_a);
        int s;
        s = (byte_a >> 1) & 3;
        return w[63 - 16 * s -: 16];
    endfunction

    function automatic logic [63:0] exp_merge(logic [63:0] w, int byte_a, logic [15:0] v);
        int s;
        logic [63:0] r;
        s = (byte_a >> 1) & 3;
        r = w;
        r[63 - 16 * s -: 16] = v;
        return r;
    endfunction

    task automatic run_req(int i, bit sect, int unit, bit lane_en, int lane, int off,
                           bit we, logic [15:0] wd,
                           output logic [15:0] rd, output logic er);
        @(negedge clk);
        req_sect[i]    = sect;
        req_unit[i]    = 4'(unit);
        req_lane_en[i] = lane_en;
        req_lane[i]    = 5'(lane);
        req_off[i]     = 9'(off);
        req_we[i]      = we;
        req_wdata[i]   = wd;
        req_valid[i]   = 1'b1;
        #1;
        while (!req_ready[i]) begin
            @(negedge clk);
            #1;
        end
        order[i] = acc_cnt;
        acc_cnt++;
        @(negedge clk);
        req_valid[i] = 1'b0;
        while (!done[i]) @(negedge clk);
        rd = done_rdata;
        er = done_err;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(mem_req == 1'b0, "R11 mem_req idle", 64'(mem_req), 0);
        chk(done == 2'b00, "R11 done idle", 64'(done), 0);
        chk(req_ready == 2'b00, "R11 ready idle", 64'(req_ready), 0);
    endtask

    task automatic t_fw_thread0();
        logic [15:0] rd;
        logic er;
        int b;
        int na, nw;
        logic [63:0] old, exp;
        b   = exp_byte(0, 0, 0, 0, 2);
        old = mem[b[12:3]];
        exp = exp_merge(old, b, 16'hBEEF);
        na  = n_access;
        nw  = n_write;
        run_req(0, 0, 0, 0, 0, 2, 1, 16'hBEEF, rd, er);
        chk(last_addr == 20'h111B0, "R3 write word address", 64'(last_addr), 64'h111B0);
        chk(mem[b[12:3]] == exp, "R5 R4 merged word", mem[b[12:3]], exp);
        chk(rd == exp_field(old, b), "R5 previous field", 64'(rd), 64'(exp_field(old, b)));
        chk(n_access - na == 2 && n_write - nw == 1, "R5 one fetch one store",
            64'(n_access - na), 2);
        na = n_access;
        nw = n_write;
        run_req(1, 0, 3, 0, 0, 2, 0, 16'h0, rd, er);
        chk(rd == 16'hBEEF && !er, "R1 unit3 shares thread0 copy", 64'(rd), 64'hBEEF);
        chk(n_access - na == 1 && n_write == nw, "R6 single fetch no store",
            64'(n_access - na), 1);
    endtask

    task automatic t_fw_thread1();
        logic [15:0] rd;
        logic er;
        int b;
        b = exp_byte(0, 1, 0, 0, 5);
        run_req(0, 0, 1, 0, 0, 5, 0, 16'h0, rd, er);
        chk(last_addr == 20'h111C8, "R2 thread1 firmware word", 64'(last_addr), 64'h111C8);
        chk(rd == exp_field(mem[b[12:3]], b), "R4 slot 1 read",
            64'(rd), 64'(exp_field(mem[b[12:3]], b)));
    endtask

    task automatic t_lanes();
        logic [15:0] rd;
        logic er;
        int b;
        logic [63:0] exp;
        b   = exp_byte(1, 2, 1, 17, 3);
        exp = exp_merge(mem[b[12:3]], b, 16'h1234);
        run_req(1, 1, 2, 1, 17, 3, 1, 16'h1234, rd, er);
        chk(last_addr == 20'h12E20, "R3 lane 17 thread1 word", 64'(last_addr), 64'h12E20);
        chk(mem[b[12:3]] == exp, "R4 slot 3 merge", mem[b[12:3]], exp);
        b   = exp_byte(1, 7, 1, 0, 0);
        exp = exp_merge(mem[b[12:3]], b, 16'hA5C3);
        run_req(0, 1, 7, 1, 0, 0, 1, 16'hA5C3, rd, er);
        chk(last_addr == 20'h12800, "R2 memory section thread0", 64'(last_addr), 64'h12800);
        chk(mem[b[12:3]] == exp, "R4 slot 0 merge", mem[b[12:3]], exp);
    endtask

    task automatic t_errors();
        logic [15:0] rd;
        logic er;
        int na;
        na = n_access;
        run_req(0, 0, 8, 0, 0, 2, 1, 16'hFFFF, rd, er);
        chk(er == 1'b1, "R7 R1 unit 8 rejected", 64'(er), 1);
        chk(n_access == na, "R7 no access for unit 8", 64'(n_access - na), 0);
        run_req(1, 1, 4, 1, 3, 16, 0, 16'h0, rd, er);
        chk(er == 1'b1 && n_access == na, "R7 lane offset 0x10 rejected", 64'(er), 1);
        run_req(0, 0, 5, 0, 0, 16, 0, 16'h0, rd, er);
        chk(er == 1'b0 && n_access == na + 1, "R7 non-lane offset 0x10 allowed",
            64'(er), 0);
    endtask

    task automatic t_arb();
        logic [15:0] r0, r1;
        logic e0, e1;
        int b0, b1;
        logic [63:0] exp;
        b0 = exp_byte(1, 0, 1, 2, 0);
        b1 = exp_byte(1, 0, 1, 2, 1);
        exp = exp_merge(exp_merge(mem[b0[12:3]], b0, 16'h1111), b1, 16'h2222);
        run_req(0, 0, 0, 0, 0, 0, 0, 16'h0, r0, e0);
        fork
            run_req(0, 1, 0, 1, 2, 0, 1, 16'h1111, r0, e0);
            run_req(1, 1, 0, 1, 2, 1, 1, 16'h2222, r1, e1);
        join
        chk(order[1] < order[0], "R9 requester 1 after 0 served", 64'(order[1]), 64'(order[0]));
        chk(mem[b0[12:3]] == exp, "R8 both slots survive", mem[b0[12:3]], exp);
        run_req(1, 0, 0, 0, 0, 0, 0, 16'h0, r1, e1);
        fork
            run_req(0, 0, 0, 0, 0, 1, 0, 16'h0, r0, e0);
            run_req(1, 0, 0, 0, 0, 3, 0, 16'h0, r1, e1);
        join
        chk(order[0] < order[1], "R9 requester 0 after 1 served", 64'(order[0]), 64'(order[1]));
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fw_thread0();
        t_fw_thread1();
        t_lanes();
        t_errors();
        t_arb();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end
endmodule